// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a general-purpose I/O port of 32 pins behind a single-cycle register port. The port has a write strobe, a word address, write data and read data. Pin direction is never written as a whole word. One register turns selected pins into outputs and another turns selected pins back into inputs. Any pin whose bit is zero in either write keeps its direction.

Output levels are kept in a per-pin latch that is reached through two half-port registers, one for pins 0 to 15 and one for pins 16 to 31. Each write to a half carries a per-pin enable in its upper half and the new levels in its lower half. Software can therefore change one pin without first reading the others. The latch keeps its contents whether the pin is an output or an input, so a level can be loaded before the pin starts driving. Pin levels are brought in through a two-flop synchronizer and can be read back from a read-only register.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0) and every output latch holds 0 (`pad_out` = 0).
- R2: A write to address 0 sets `pad_oe[i]` for each bit i that is 1 in `wdata`. Pins whose bit is 0 keep their direction.
- R3: A write to address 1 clears `pad_oe[i]` for each bit i that is 1 in `wdata`. Pins whose bit is 0 keep their direction.
- R4: A write to address 2 updates the latch of pin k (0 to 15) to `wdata[k]` only where `wdata[16+k]` is 1. Every other pin keeps its level.
- R5: A write to address 3 updates the latch of pin 16+k (k from 0 to 15) to `wdata[k]` only where `wdata[16+k]` is 1. Every other pin keeps its level.
- R6: `pad_out` always shows the latch, whatever the direction. A level loaded while a pin is an input is already on `pad_out` in the same cycle that `pad_oe` rises, and changing the direction never alters the latch.
- R7: With `addr` = 4, `rdata` returns `pad_in` as it was two clock edges earlier, one bit per pin.
- R8: Writes to addresses 4 to 7 change neither direction nor latches. Reads from any address other than 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_oe | output | 32 | Per-pin output enable (1 = output) |
| pad_out | output | 32 | Per-pin output level |

## Verification
The hardest case to reach from the ports is a write that enables only a few scattered pins in one half. In that case the pins left out of the enable must keep levels that an earlier write set up. The bench first loads a known pattern into both halves. It then applies dozens of writes whose enable and data fields come from independent multiplicative hashes, so that every pin sees enabled-high, enabled-low and disabled cases against both previous levels. A reference model in the bench tracks the expected latch. The pre-loading of a level while a pin is an input is checked by changing direction after the latch write and requiring `pad_out` to stay fixed across that change.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out
);
  localparam int HALF = PINS / 2;
  localparam logic [2:0] A_DSET = 3'd0;
  localparam logic [2:0] A_DCLR = 3'd1;
  localparam logic [2:0] A_OLO  = 3'd2;
  localparam logic [2:0] A_OHI  = 3'd3;
  localparam logic [2:0] A_PIN  = 3'd4;

  logic [PINS-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic [HALF-1:0] msk, dat;

  assign msk = wdata[PINS-1:HALF];
  assign dat = wdata[HALF-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (wr_en && addr == A_DSET) begin
      dir_q <= dir_q | wdata;
    end else if (wr_en && addr == A_DCLR) begin
      dir_q <= dir_q & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (wr_en && addr == A_OLO) begin
      lat_q[HALF-1:0] <= (lat_q[HALF-1:0] & ~msk) | (dat & msk);
    end else if (wr_en && addr == A_OHI) begin
      lat_q[PINS-1:HALF] <= (lat_q[PINS-1:HALF] & ~msk) | (dat & msk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign rdata   = (addr == A_PIN) ? sync2_q : '0;
  assign pad_oe  = dir_q;
  assign pad_out = lat_q;
endmodule

module gpio_mask_port_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [PINS-1:0] wdata,
  input logic [PINS-1:0] rdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] pad_out
);
  localparam int HALF = PINS / 2;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> ((pad_oe & $past(wdata)) == $past(wdata)));
  // R3
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> ((pad_oe & $past(wdata)) == '0));
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 3'd0 || addr == 3'd1)) |=> $stable(pad_oe));
  // R4
  lo_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> (pad_out[HALF-1:0] ==
      (($past(pad_out[HALF-1:0]) & ~$past(wdata[PINS-1:HALF])) |
       ($past(wdata[HALF-1:0]) & $past(wdata[PINS-1:HALF])))));
  // R5
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd3) |=> $stable(pad_out[PINS-1:HALF]));
  // R6
  lat_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= 3'd1) |=> $stable(pad_out));
  // R7
  sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && addr == 3'd4) |-> (rdata == $past(pad_in, 2)));
  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 3'd4) |-> (rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  localparam int CLK_NS = 10;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_oe, pad_out;
  logic [31:0] m_oe, m_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_mask_port i_gpio_mask_port (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
    m_oe = '0; m_out = '0;

    for (int i = 0; i < 32; i++) begin
      wr(3'd0, 32'h1 << i);
      m_oe |= 32'h1 << i;
      check("R2 walk set", pad_oe, m_oe);
    end
    for (int i = 0; i < 32; i += 3) begin
      wr(3'd1, 32'h1 << i);
      m_oe &= ~(32'h1 << i);
      check("R3 walk clr", pad_oe, m_oe);
    end
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v;
      v = (k * 32'h2545F491) ^ 32'h5A5A0F0F;
      wr((k % 2) ? 3'd1 : 3'd0, v);
      m_oe = (k % 2) ? (m_oe & ~v) : (m_oe | v);
      check((k % 2) ? "R3 pattern" : "R2 pattern", pad_oe, m_oe);
    end

    wr(3'd2, 32'hFFFF_C3A5); m_out[15:0] = 16'hC3A5;
    check("R4 full", pad_out, m_out);
    wr(3'd3, 32'hFFFF_5E71); m_out[31:16] = 16'h5E71;
    check("R5 full", pad_out, m_out);
    for (int k = 0; k < 64; k++) begin
      logic [15:0] mk, dt;
      mk = 16'((k + 1) * 32'h9E3779B1 >> 7);
      dt = 16'((k + 3) * 32'h85EBCA6B >> 11);
      if (k % 2 == 0) begin
        wr(3'd2, {mk, dt});
        m_out[15:0] = (m_out[15:0] & ~mk) | (dt & mk);
        check("R4 masked", pad_out, m_out);
      end else begin
        wr(3'd3, {mk, dt});
        m_out[31:16] = (m_out[31:16] & ~mk) | (dt & mk);
        check("R5 masked", pad_out, m_out);
      end
    end

    wr(3'd1, 32'hFFFF_FFFF); m_oe = '0;
    wr(3'd3, 32'hFFFF_A5C3); m_out[31:16] = 16'hA5C3;
    wr(3'd2, 32'hFFFF_0FF0); m_out[15:0] = 16'h0FF0;
    check("R6 preload while input", pad_out, m_out);
    wr(3'd0, 32'hFFFF_FFFF); m_oe = '1;
    check("R6 oe", pad_oe, m_oe);
    check("R6 out on switch", pad_out, m_out);
    wr(3'd1, 32'h0000_FFFF); m_oe = 32'hFFFF_0000;
    check("R6 out after clr", pad_out, m_out);

    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      check("R8 oe ignored", pad_oe, m_oe);
      check("R8 out ignored", pad_out, m_out);
    end
    for (int a = 0; a < 8; a++) begin
      if (a == 4) continue;
      @(negedge clk); addr = 3'(a); pad_in = 32'hDEAD_BEEF;
      #1 check("R8 read zero", rdata, 32'h0);
    end

    @(negedge clk); addr = 3'd4;
    for (int k = 0; k < 12; k++) begin
      logic [31:0] prev, v;
      prev = pad_in;
      v = (k * 32'h7FEB352D) ^ (32'h1 << k);
      pad_in = v;
      @(negedge clk);
      check("R7 one edge", rdata, prev);
      @(negedge clk);
      check("R7 two edges", rdata, v);
    end
    finish_run();
  end
endmodule